// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

An eight-input interrupt controller that a processor programs through a byte-wide register interface. Rising edges or levels on the request lines are latched into a request register and filtered by a mask register. A priority resolver, whose lowest-priority position can be rotated, picks one winning level. The winner drives an interrupt output and a vector number built from a programmed base. Serviced levels are tracked in an in-service register until software ends them with an end-of-interrupt command, or until hardware clears them in automatic end-of-interrupt mode.

Software first runs an initialization sequence: one command-port byte, then three data-port bytes. After that it uses operation commands for end-of-interrupt, rotation, special mask mode, poll mode and read-back selection. The interrupt is taken either with a one-cycle acknowledge strobe or with a poll read of the command port. A separate trigger register marks each input as edge or level sensitive.

Register map (addr_i): 0 is the command port, 1 is the data port, 2 is the trigger register (bit set = level sensitive). Address 3 reads zero and ignores writes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A command write with bit 4 set clears the request, in-service and mask registers and all mode flags, sets the lowest-priority pointer to 7, and restarts initialization.
- R2: After that word, three data writes are taken in turn: the vector base (bits 7:3 used), a cascade byte (ignored), and a mode byte whose bit 1 enables automatic end-of-interrupt. Later data writes load the mask, and data reads return the mask. int_o stays low until the sequence completes.
- R3: The winner is the first candidate found scanning upward with wraparound from the level after the pointer. int_o is high when an unmasked request wins and is not blocked. vector_o is the base with the winning level in bits 2:0. A masked request stays in the request register.
- R4: An acknowledge (inta_i high for one cycle) clears the winner's request bit and sets its in-service bit. An in-service level blocks itself and every level of lower priority.
- R5: Command 0x20 clears the highest-priority in-service bit. Command 0x60|n clears in-service bit n.
- R6: Command 0xC0|n sets the pointer to n. Command 0xA0 clears the highest in-service bit and loads the pointer with that level. Command 0xE0|n clears in-service bit n and sets the pointer to n.
- R7: In automatic end-of-interrupt mode an acknowledge leaves the in-service register unchanged. Command 0x80 enables rotation on acknowledge (pointer takes the acknowledged level), and command 0x00 disables it.
- R8: Command 0x68 enables special mask mode and 0x48 disables it. While it is on and the mask is nonzero, in-service bits block no request.
- R9: Command 0x0C arms poll mode. The next command-port read returns 0x80|level and acknowledges that level, or returns 0 when nothing is pending. The read clears poll mode.
- R10: Command 0x0B makes command-port reads return the in-service register. Command 0x0A makes them return the request register, which is the state after reset.
- R11: An edge-sensitive input (trigger bit 0) sets its request bit on a rising edge of the line. The bit stays set after the line falls and clears on acknowledge.
- R12: For a level-sensitive input (trigger bit 1), the request bit follows the line one cycle later. The trigger register is written and read at address 2 and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects only for poll) |
| addr_i | input | 2 | Register select: 0 command, 1 data, 2 trigger |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_lines_i | input | 8 | Interrupt request lines, active high |
| inta_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector of the current winner |

## Verification
The assertions assume that rd_i and wr_i are never high in the same cycle, and that acknowledges and command writes do not share a cycle. They also assume the request lines are synchronous to clk_i and low while reset is applied. The bench drives every input on the falling edge and performs one register access, acknowledge or line change per transaction. It releases the lines before each new initialization, so every rising edge the bench expects is one the design can see.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_W2, ST_W3, ST_W4, ST_READY} init_st_e;

  typedef struct packed {
    logic aeoi;
    logic rot_aeoi;
    logic smm;
    logic poll;
    logic rd_isr;
  } mode_t;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;
endpackage

// File: rtl/irq_prio_resolver.sv
`timescale 1ns/1ps
module irq_prio_resolver #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [LW-1:0] low_i,
  output logic          found_o,
  output logic [LW-1:0] lvl_o
);
  logic [LW-1:0] idx;

  // scan from farthest to nearest; the nearest hit above low_i wins
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    idx     = '0;
    for (int k = N; k >= 1; k--) begin
      idx = LW'((int'(low_i) + k) % N);
      if (req_i[idx]) begin
        found_o = 1'b1;
        lvl_o   = idx;
      end
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
`timescale 1ns/1ps
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] ack_clr_i,
  input  logic         init_clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q, irr_q, irr_d, rise;

  assign rise  = line_i & ~prev_q;
  assign irr_o = irr_q;

  always_comb begin
    irr_d = (level_i & line_i) | (~level_i & (irr_q | rise) & ~ack_clr_i);
    if (init_clr_i) irr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= line_i;
      irr_q  <= irr_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_edge_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!level_i[i] && line_i[i] && !prev_q[i] && !init_clr_i && !ack_clr_i[i]) |=> irr_q[i]);
    assert_level_follow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_i[i] && !init_clr_i) |=> (irr_q[i] == $past(line_i[i])));
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] irq_lines_i,
  input  logic       inta_i,
  output logic       int_o,
  output logic [7:0] vector_o
);
  localparam int N  = 8;
  localparam int LW = $clog2(N);
  localparam int BW = 8 - LW;

  init_st_e      step_q, step_d;
  mode_t         mode_q, mode_d;
  logic [N-1:0]  imr_q, imr_d, isr_q, isr_d, trig_q, trig_d;
  logic [LW-1:0] prio_q, prio_d;
  logic [BW-1:0] base_q, base_d;

  logic [N-1:0]  irr, blk, cand, ack_vec;
  logic          cmd_wr, data_wr, trig_wr, icw1, ocw2, ocw3;
  logic          win_found, pend, top_found, poll_rd, ack_go;
  logic [LW-1:0] win_lvl, top_lvl;

  assign cmd_wr  = wr_i && (addr_i == ADDR_CMD);
  assign data_wr = wr_i && (addr_i == ADDR_DATA);
  assign trig_wr = wr_i && (addr_i == ADDR_TRIG);
  assign icw1    = cmd_wr && wdata_i[4];
  assign ocw2    = cmd_wr && (wdata_i[4:3] == 2'b00);
  assign ocw3    = cmd_wr && !wdata_i[7] && (wdata_i[4:3] == 2'b01);

  // special mask mode with a live mask drops in-service blocking
  assign blk  = (mode_q.smm && (imr_q != '0)) ? '0 : isr_q;
  assign cand = (irr & ~imr_q) | blk;

  irq_prio_resolver #(.N(N)) u_win (
    .req_i(cand), .low_i(prio_q), .found_o(win_found), .lvl_o(win_lvl)
  );

  irq_prio_resolver #(.N(N)) u_top_isr (
    .req_i(isr_q), .low_i(prio_q), .found_o(top_found), .lvl_o(top_lvl)
  );

  assign pend    = win_found && !blk[win_lvl];
  assign poll_rd = rd_i && (addr_i == ADDR_CMD) && !mode_q.rd_isr && mode_q.poll;
  assign ack_go  = pend && (inta_i || poll_rd);

  always_comb begin
    ack_vec = '0;
    if (ack_go) ack_vec[win_lvl] = 1'b1;
  end

  irq_req_latch #(.N(N)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (irq_lines_i),
    .level_i   (trig_q),
    .ack_clr_i (ack_vec),
    .init_clr_i(icw1),
    .irr_o     (irr)
  );

  assign int_o    = (step_q == ST_READY) && pend;
  assign vector_o = {base_q, win_lvl};

  always_comb begin
    unique case (addr_i)
      ADDR_CMD: begin
        if (mode_q.rd_isr)   rdata_o = isr_q;
        else if (mode_q.poll) rdata_o = pend ? {1'b1, {(BW-1){1'b0}}, win_lvl} : 8'h00;
        else                  rdata_o = irr;
      end
      ADDR_DATA: rdata_o = imr_q;
      ADDR_TRIG: rdata_o = trig_q;
      default:   rdata_o = 8'h00;
    endcase
  end

  always_comb begin
    step_d = step_q;
    mode_d = mode_q;
    imr_d  = imr_q;
    isr_d  = isr_q;
    prio_d = prio_q;
    base_d = base_q;
    trig_d = trig_q;

    if (ack_go) begin
      isr_d[win_lvl] = 1'b1;
      if (mode_q.aeoi) begin
        isr_d[win_lvl] = 1'b0;
        if (mode_q.rot_aeoi) prio_d = win_lvl;
      end
    end
    if (poll_rd) mode_d.poll = 1'b0;

    if (icw1) begin
      isr_d  = '0;
      imr_d  = '0;
      prio_d = LW'(N - 1);
      mode_d = '0;
      step_d = ST_W2;
    end else if (ocw2) begin
      unique case (wdata_i[7:5])
        3'd0: mode_d.rot_aeoi = 1'b0;
        3'd1: if (top_found) isr_d[top_lvl] = 1'b0;
        3'd2: ;
        3'd3: isr_d[wdata_i[LW-1:0]] = 1'b0;
        3'd4: mode_d.rot_aeoi = 1'b1;
        3'd5: if (top_found) begin
          isr_d[top_lvl] = 1'b0;
          prio_d         = top_lvl;
        end
        3'd6: prio_d = wdata_i[LW-1:0];
        3'd7: begin
          isr_d[wdata_i[LW-1:0]] = 1'b0;
          prio_d                 = wdata_i[LW-1:0];
        end
        default: ;
      endcase
    end else if (ocw3) begin
      if (wdata_i[6]) mode_d.smm    = wdata_i[5];
      if (wdata_i[2]) mode_d.poll   = 1'b1;
      if (wdata_i[1]) mode_d.rd_isr = wdata_i[0];
    end

    if (data_wr) begin
      unique case (step_q)
        ST_W2: begin
          base_d = wdata_i[7:LW];
          step_d = ST_W3;
        end
        ST_W3: step_d = ST_W4;
        ST_W4: begin
          mode_d.aeoi = wdata_i[1];
          step_d      = ST_READY;
        end
        default: imr_d = wdata_i;
      endcase
    end
    if (trig_wr) trig_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      mode_q <= '0;
      imr_q  <= '0;
      isr_q  <= '0;
      prio_q <= LW'(N - 1);
      base_q <= '0;
      trig_q <= '0;
    end else begin
      step_q <= step_d;
      mode_q <= mode_d;
      imr_q  <= imr_d;
      isr_q  <= isr_d;
      prio_q <= prio_d;
      base_q <= base_d;
      trig_q <= trig_d;
    end
  end

  assert_init_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1 |=> (isr_q == '0 && imr_q == '0 && irr == '0 && prio_q == LW'(N - 1) && step_q == ST_W2));
  assert_int_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr[vector_o[LW-1:0]] && !imr_q[vector_o[LW-1:0]]));
  assert_int_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != ST_READY) |=> ($past(data_wr) || !int_o));
  assert_ack_isr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_go && !mode_q.aeoi && !cmd_wr) |=> isr_q[$past(win_lvl)]);
  assert_aeoi_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_go && mode_q.aeoi && !cmd_wr) |=> (isr_q == $past(isr_q)));
  assert_poll_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !wr_i) |=> !mode_q.poll);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, inta_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00, irq_lines_i = 8'h00;
  logic [7:0] rdata_o, vector_o;
  logic       int_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_lines_i(irq_lines_i),
    .inta_i(inta_i), .int_o(int_o), .vector_o(vector_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    inta_i = 1'b1;
    @(negedge clk);
    inta_i = 1'b0;
  endtask

  task automatic set_lines(input logic [7:0] v);
    @(negedge clk);
    irq_lines_i = v;
    @(negedge clk);
  endtask

  task automatic init_ctrl(input logic [7:0] base, input logic [7:0] w4);
    do_wr(2'd0, 8'h11);
    do_wr(2'd1, base);
    do_wr(2'd1, 8'h04);
    do_wr(2'd1, w4);
  endtask

  task automatic chk_int(input string tag, input logic exp_int, input logic [7:0] exp_vec);
    #1;
    chk({tag, " int"}, {7'd0, int_o}, {7'd0, exp_int});
    if (exp_int) chk({tag, " vector"}, vector_o, exp_vec);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk_int("R2 reset int", 1'b0, 8'h00);
    do_rd(2'd1, d); chk("R2 reset mask", d, 8'h00);
    do_rd(2'd2, d); chk("R12 reset trigger", d, 8'h00);
    do_rd(2'd0, d); chk("R10 reset irr", d, 8'h00);
  endtask

  task automatic t_init_mask();
    logic [7:0] d;
    set_lines(8'h08);
    do_rd(2'd0, d); chk("R11 edge latch", d, 8'h08);
    chk_int("R2 no int before init", 1'b0, 8'h00);
    init_ctrl(8'h20, 8'h01);
    do_rd(2'd0, d); chk("R1 irr cleared", d, 8'h00);
    do_rd(2'd1, d); chk("R1 mask cleared", d, 8'h00);
    set_lines(8'h00);
    set_lines(8'h08);
    chk_int("R3 single request", 1'b1, 8'h23);
    do_wr(2'd1, 8'h08);
    chk_int("R3 masked", 1'b0, 8'h00);
    do_rd(2'd0, d); chk("R3 masked stays in irr", d, 8'h08);
    do_rd(2'd1, d); chk("R2 mask readback", d, 8'h08);
    do_wr(2'd1, 8'h00);
    chk_int("R3 unmasked", 1'b1, 8'h23);
  endtask

  task automatic t_ack_eoi();
    logic [7:0] d;
    do_ack();
    do_wr(2'd0, 8'h0B);
    do_rd(2'd0, d); chk("R4 isr after ack", d, 8'h08);
    do_wr(2'd0, 8'h0A);
    do_rd(2'd0, d); chk("R10 irr after ack", d, 8'h00);
    set_lines(8'h28);
    chk_int("R4 lower blocked", 1'b0, 8'h00);
    set_lines(8'h2A);
    chk_int("R3 higher wins", 1'b1, 8'h21);
    do_ack();
    do_wr(2'd0, 8'h0B);
    do_rd(2'd0, d); chk("R10 isr select", d, 8'h0A);
    do_wr(2'd0, 8'h20);
    do_rd(2'd0, d); chk("R5 nonspecific eoi", d, 8'h08);
    chk_int("R4 still blocked", 1'b0, 8'h00);
    do_wr(2'd0, 8'h63);
    do_rd(2'd0, d); chk("R5 specific eoi", d, 8'h00);
    chk_int("R5 unblocked", 1'b1, 8'h25);
    do_ack();
    do_rd(2'd0, d); chk("R4 isr level5", d, 8'h20);
    do_wr(2'd0, 8'h20);
    do_rd(2'd0, d); chk("R5 eoi level5", d, 8'h00);
    set_lines(8'h00);
  endtask

  task automatic t_rotate();
    init_ctrl(8'h68, 8'h01);
    do_wr(2'd0, 8'hC3);
    set_lines(8'h12);
    chk_int("R6 set pointer", 1'b1, 8'h6C);
    do_ack();
    chk_int("R4 level4 blocks", 1'b0, 8'h00);
    do_wr(2'd0, 8'hA0);
    chk_int("R6 rotate nonspecific", 1'b1, 8'h69);
    do_ack();
    do_wr(2'd0, 8'hE1);
    set_lines(8'h00);
    set_lines(8'h05);
    chk_int("R6 rotate specific", 1'b1, 8'h6A);
    set_lines(8'h00);
  endtask

  task automatic t_aeoi();
    logic [7:0] d;
    init_ctrl(8'h20, 8'h03);
    do_wr(2'd0, 8'h80);
    set_lines(8'h21);
    chk_int("R7 first winner", 1'b1, 8'h20);
    do_ack();
    do_wr(2'd0, 8'h0B);
    do_rd(2'd0, d); chk("R7 isr untouched", d, 8'h00);
    chk_int("R7 rotated on ack", 1'b1, 8'h25);
    do_wr(2'd0, 8'h00);
    do_ack();
    set_lines(8'h00);
    set_lines(8'h03);
    chk_int("R7 rotation off", 1'b1, 8'h21);
    do_rd(2'd0, d); chk("R7 isr still clear", d, 8'h00);
    set_lines(8'h00);
  endtask

  task automatic t_smm();
    init_ctrl(8'h20, 8'h01);
    set_lines(8'h01);
    do_ack();
    set_lines(8'h05);
    chk_int("R4 blocked by level0", 1'b0, 8'h00);
    do_wr(2'd1, 8'h80);
    do_wr(2'd0, 8'h68);
    chk_int("R8 special mask on", 1'b1, 8'h22);
    do_wr(2'd0, 8'h48);
    chk_int("R8 special mask off", 1'b0, 8'h00);
    set_lines(8'h00);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    init_ctrl(8'h20, 8'h01);
    do_wr(2'd0, 8'h0C);
    do_rd(2'd0, d); chk("R9 poll empty", d, 8'h00);
    set_lines(8'h40);
    do_rd(2'd0, d); chk("R9 poll flag cleared", d, 8'h40);
    chk_int("R3 level6", 1'b1, 8'h26);
    do_wr(2'd0, 8'h0C);
    do_rd(2'd0, d); chk("R9 poll hit", d, 8'h86);
    chk_int("R9 poll acknowledged", 1'b0, 8'h00);
    do_wr(2'd0, 8'h0B);
    do_rd(2'd0, d); chk("R9 isr after poll", d, 8'h40);
    set_lines(8'h00);
  endtask

  task automatic t_trigger();
    logic [7:0] d;
    init_ctrl(8'h20, 8'h01);
    do_wr(2'd2, 8'h08);
    do_rd(2'd2, d); chk("R12 trigger readback", d, 8'h08);
    set_lines(8'h08);
    do_rd(2'd0, d); chk("R12 level high", d, 8'h08);
    chk_int("R12 level int", 1'b1, 8'h23);
    set_lines(8'h00);
    do_rd(2'd0, d); chk("R12 level low", d, 8'h00);
    chk_int("R12 level int gone", 1'b0, 8'h00);
    set_lines(8'h10);
    set_lines(8'h00);
    do_rd(2'd0, d); chk("R11 edge held", d, 8'h10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_init_mask();
    t_ack_eoi();
    t_rotate();
    t_aeoi();
    t_smm();
    t_poll();
    t_trigger();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule